// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller

This block gives a processor control over a 16-pin general purpose I/O bus through four word-addressed registers on a simple single-cycle bus port. Software sets which pins are driven through an active-low direction register, supplies the driven levels through an output data register, and reads the pin levels back after a two-flop synchroniser. Each pin can also request an interrupt. Requests are level-sensitive and active-high on the synchronised input, and the block merges all enabled requests into one interrupt line toward the processor.

A strap input selects endpoint mode. In that mode the four lowest pins are taken away from general purpose use. They are always driven, and they carry four active-low interrupt signals supplied from elsewhere in the chip, whatever the direction and data registers hold. While reset is held, every pin is left undriven. The input path keeps sampling the pins during reset, so the input register already shows the pin levels when reset is released.

Top module: `gpio_ctrl`

## Requirements
- R1: After a reset, the direction register (offset 0x0) reads 0xFFFF, and the output data register (offset 0x8) and the interrupt enable register (offset 0xC) both read 0x0000. All pins are then undriven, unless endpoint mode applies its override to the low four pins (R4).
- R2: While `rst_n` is low, `pin_oe` is 0 on every bit.
- R3: Outside endpoint mode, pin i is driven (`pin_oe[i]`=1) exactly when direction bit i is 0, and `pin_out[i]` equals output data bit i.
- R4: With `endpoint_mode`=1 and reset released, `pin_oe[3:0]` is all ones and `pin_out[3:0]` equals `alt_irq_n`, whatever the direction and data registers hold. Pins 15 to 4 still follow R3.
- R5: A read at offset 0x4 returns the pin levels sampled two rising edges earlier. The sampling also runs while reset is held.
- R6: A write with `bus_wen`=1 at offset 0x0, 0x8 or 0xC loads `bus_wdata` on that rising edge, so the value reads back and reaches the pins in the following cycle.
- R7: Writes to offset 0x4 or to any unmapped offset change no register.
- R8: Reads of any offset other than 0x0, 0x4, 0x8 or 0xC return zero.
- R9: `irq` is 1 exactly when some pin has both its interrupt enable bit set and its synchronised input level high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| endpoint_mode | input | 1 | Strap: low four pins carry the alternate interrupt outputs |
| alt_irq_n | input | 4 | Active-low interrupt signals driven on pins 3..0 in endpoint mode |
| pin_in | input | 16 | Levels seen at the pads |
| pin_out | output | 16 | Levels to drive at the pads |
| pin_oe | output | 16 | Pad drive enable, 1 = driven |
| irq | output | 1 | Merged pin interrupt request |

## Verification
The state that is hardest to reach from the ports is the input register holding pin levels that were sampled while reset was still asserted, at the same time as endpoint mode overrides the low pins. The bench applies a known pattern to the pins and holds reset for several cycles, once with the strap low and once with it high. It then reads offset 0x4 in the first cycle after release and checks the drive state of the low pins. Random phases follow. They mix writes to mapped, read-only and unmapped offsets with changing pin levels, so that the interrupt line rises and falls under many combinations of enable masks.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants for the GPIO controller: bus address width and the
// byte offsets of the four registers. Assumes word-aligned offsets.
package gpio_ctrl_pkg;
    parameter int unsigned GPIO_AW = 4;

    localparam logic [GPIO_AW-1:0] OFS_DIR = 4'h0;  // active-low drive enable
    localparam logic [GPIO_AW-1:0] OFS_IN  = 4'h4;  // synchronised pin levels, read-only
    localparam logic [GPIO_AW-1:0] OFS_OUT = 4'h8;  // output data
    localparam logic [GPIO_AW-1:0] OFS_IEN = 4'hC;  // per-pin interrupt enable
endpackage

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for the pad inputs. It has no reset, so it keeps
// sampling while the block is held in reset. Assumes STAGES >= 2.
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // shift the pad levels through the flop chain
    always_ff @(posedge clk) begin
        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// Register file for the GPIO controller: direction (active low), output data
// and interrupt enable, plus a combinational read mux. Assumes a single-cycle
// bus with no wait states. The input register is the synchroniser output.
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wen,
    input  logic [GPIO_AW-1:0] addr,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH-1:0]   in_level,
    output logic [WIDTH-1:0]   rdata,
    output logic [WIDTH-1:0]   dir_q,
    output logic [WIDTH-1:0]   dout_q,
    output logic [WIDTH-1:0]   ien_q
);
    // reset to all-input, load the addressed writable register on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            dout_q <= '0;
            ien_q  <= '0;
        end else if (wen) begin
            case (addr)
                OFS_DIR: dir_q  <= wdata;
                OFS_OUT: dout_q <= wdata;
                OFS_IEN: ien_q  <= wdata;
                default: ;
            endcase
        end
    end

    // select read data, zero for unmapped offsets
    always_comb begin
        case (addr)
            OFS_DIR: rdata = dir_q;
            OFS_IN:  rdata = in_level;
            OFS_OUT: rdata = dout_q;
            OFS_IEN: rdata = ien_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
// Pad drive control. Turns the active-low direction bits into pad drive
// enables, holds every pad undriven during reset, and lets the endpoint strap
// hand the low ALT_W pads to the alternate interrupt outputs.
// Assumes ALT_W <= WIDTH.
module gpio_pad_ctl #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned ALT_W = 4
) (
    input  logic             rst_n,
    input  logic             ep_mode,
    input  logic [WIDTH-1:0] dir_n,
    input  logic [WIDTH-1:0] dout,
    input  logic [ALT_W-1:0] alt_n,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i < ALT_W) begin : g_alt
            // shared pin: the strap forces drive and selects the alternate level
            assign pad_oe[i] = rst_n & (ep_mode | ~dir_n[i]);
            assign pad_o[i]  = ep_mode ? alt_n[i] : dout[i];
        end else begin : g_gp
            // plain pin: register-controlled drive and level
            assign pad_oe[i] = rst_n & ~dir_n[i];
            assign pad_o[i]  = dout[i];
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
// GPIO controller top: synchroniser, register file, pad control and the
// merged level-sensitive interrupt. Assumes endpoint_mode is a static strap
// that only changes while rst_n is low.
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned ALT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wen,
    input  logic [GPIO_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]   bus_wdata,
    output logic [WIDTH-1:0]   bus_rdata,
    input  logic               endpoint_mode,
    input  logic [ALT_W-1:0]   alt_irq_n,
    input  logic [WIDTH-1:0]   pin_in,
    output logic [WIDTH-1:0]   pin_out,
    output logic [WIDTH-1:0]   pin_oe,
    output logic               irq
);
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dout_q;
    logic [WIDTH-1:0] ien_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .din  (pin_in),
        .dout (sync_q)
    );

    gpio_regfile #(.WIDTH(WIDTH)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (bus_wen),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .in_level (sync_q),
        .rdata    (bus_rdata),
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .ien_q    (ien_q)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH), .ALT_W(ALT_W)) pads_i (
        .rst_n   (rst_n),
        .ep_mode (endpoint_mode),
        .dir_n   (dir_q),
        .dout    (dout_q),
        .alt_n   (alt_irq_n),
        .pad_oe  (pin_oe),
        .pad_o   (pin_out)
    );

    // merge enabled, high, synchronised pin levels into one request
    assign irq = |(sync_q & ien_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
// Assertion checker for gpio_ctrl, attached by bind. Reaches the register
// outputs and synchroniser output of the top through the bind connections.
module gpio_ctrl_chk
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned ALT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wen,
    input logic [GPIO_AW-1:0] bus_addr,
    input logic [WIDTH-1:0]   bus_wdata,
    input logic [WIDTH-1:0]   bus_rdata,
    input logic               endpoint_mode,
    input logic [ALT_W-1:0]   alt_irq_n,
    input logic [WIDTH-1:0]   pin_in,
    input logic [WIDTH-1:0]   pin_out,
    input logic [WIDTH-1:0]   pin_oe,
    input logic               irq,
    input logic [WIDTH-1:0]   dir_q,
    input logic [WIDTH-1:0]   dout_q,
    input logic [WIDTH-1:0]   ien_q,
    input logic [WIDTH-1:0]   sync_q
);
    // R1: registers hold their reset values on the first cycle after release
    a_r1_reset_values: assert property (@(posedge clk)
        $rose(rst_n) |-> (dir_q == '1 && dout_q == '0 && ien_q == '0));

    // R2: no pad is driven while reset is held
    a_r2_tristate_in_reset: assert property (@(posedge clk)
        !rst_n |-> (pin_oe == '0));

    // R4: endpoint strap owns the low pins
    a_r4_alt_override: assert property (@(posedge clk) disable iff (!rst_n)
        endpoint_mode |-> (pin_oe[ALT_W-1:0] == '1 && pin_out[ALT_W-1:0] == alt_irq_n));

    // R6: a direction write is visible one cycle later
    a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

    // R7: writes to the read-only offset leave every register alone
    a_r7_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_IN) |=> ($stable(dir_q) && $stable(dout_q) && $stable(ien_q)));

    // R8: unmapped offsets read zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_DIR && bus_addr != OFS_IN && bus_addr != OFS_OUT && bus_addr != OFS_IEN)
        |-> (bus_rdata == '0));

    if (SYNC_STAGES == 2) begin : g_two_stage
        // R5: input register trails the pads by two edges
        a_r5_in_latency: assert property (@(posedge clk) disable iff (!rst_n)
            sync_q == $past(pin_in, 2));

        // R9: interrupt follows enabled pad levels seen two edges back
        a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (|($past(pin_in, 2) & ien_q)));
    end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .WIDTH(WIDTH), .ALT_W(ALT_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .endpoint_mode(endpoint_mode),
    .alt_irq_n(alt_irq_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq), .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .sync_q(sync_q)
);

// File: tb/gpio_ctrl_tb_top.sv
// Self-checking bench for gpio_ctrl: directed corner cases plus seeded random
// traffic, compared against a bench-side model of the registers and pins.
module gpio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        endpoint_mode = 1'b0;
    logic [3:0]  alt_irq_n = 4'hF;
    logic [15:0] pin_in = 16'h0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_dir, m_dout, m_ien, m_s1, m_s2;

    always #4 clk = ~clk;

    gpio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .endpoint_mode(endpoint_mode),
        .alt_irq_n(alt_irq_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq)
    );

    function automatic logic [15:0] exp_rd(logic [3:0] a);
        case (a)
            4'h0: return m_dir;
            4'h4: return m_s2;
            4'h8: return m_dout;
            4'hC: return m_ien;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] v;
        if (!rst_n) return 16'h0;
        v = ~m_dir;
        if (endpoint_mode) v[3:0] = 4'hF;
        return v;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] v;
        v = m_dout;
        if (endpoint_mode) v[3:0] = alt_irq_n;
        return v;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one rising edge: update the model with what the design sees, then settle
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_dir = 16'hFFFF; m_dout = 16'h0; m_ien = 16'h0;
        end else if (bus_wen) begin
            case (bus_addr)
                4'h0: m_dir  = bus_wdata;
                4'h8: m_dout = bus_wdata;
                4'hC: m_ien  = bus_wdata;
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pin_in;
        @(negedge clk);
    endtask

    task automatic write(logic [3:0] a, logic [15:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wen = 1'b0;
    endtask

    // compare pins, interrupt and every readable offset against the model
    task automatic check_all(string tag);
        logic [3:0] offs [6] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h2, 4'hE};
        bus_wen = 1'b0;
        chk({tag, " R2/R3/R4 pin_oe"}, pin_oe, exp_oe());
        if (rst_n) begin
            chk({tag, " R3/R4 pin_out"}, pin_out, exp_out());
            chk({tag, " R9 irq"}, {15'h0, irq}, {15'h0, |(m_s2 & m_ien)});
            foreach (offs[k]) begin
                bus_addr = offs[k];
                #1;
                chk($sformatf("%s R1/R5/R6/R7/R8 read %h", tag, offs[k]), bus_rdata, exp_rd(offs[k]));
            end
        end
    endtask

    task automatic do_reset(bit ep, logic [15:0] pins);
        rst_n = 1'b0; endpoint_mode = ep; pin_in = pins;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R2 tristate during reset", pin_oe, 16'h0);
        end
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // reset with a known pad pattern: input register shows it at release
        do_reset(1'b0, 16'hA5A5);
        bus_addr = 4'h4; #1;
        chk("R5 pins sampled during reset", bus_rdata, 16'hA5A5);
        bus_addr = 4'h0; #1;
        chk("R1 dir reset value", bus_rdata, 16'hFFFF);
        chk("R1 all pins undriven", pin_oe, 16'h0);
        check_all("R1 post-reset");

        // drive half the pins
        write(4'h0, 16'h00FF);
        write(4'h8, 16'h1234);
        chk("R3 drive enables", pin_oe, 16'hFF00);
        chk("R6 data on pins", pin_out, 16'h1234);
        check_all("R6 directed");

        // read-only and unmapped writes are dropped
        write(4'h4, 16'hDEAD);
        write(4'h2, 16'hBEEF);
        write(4'hE, 16'h0000);
        bus_addr = 4'h2; #1;
        chk("R8 unmapped reads zero", bus_rdata, 16'h0);
        check_all("R7 ignored writes");

        // two-edge input latency
        pin_in = 16'h0F0F; step();
        pin_in = 16'h3C3C; step();
        bus_addr = 4'h4; #1;
        chk("R5 one edge later still old", bus_rdata, 16'h0F0F);
        step(); bus_addr = 4'h4; #1;
        chk("R5 two edges later", bus_rdata, 16'h3C3C);

        // interrupt on one pin, level sensitive
        write(4'hC, 16'h0010);
        pin_in = 16'h0010; step(); step();
        chk("R9 irq asserted", {15'h0, irq}, 16'h1);
        pin_in = 16'h0000; step(); step();
        chk("R9 irq released", {15'h0, irq}, 16'h0);
        pin_in = 16'hFFEF; step(); step();
        chk("R9 masked pins ignored", {15'h0, irq}, 16'h0);

        // random traffic in general mode
        for (int i = 0; i < 400; i++) begin
            logic [3:0] offs [6] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h6, 4'hD};
            bus_wen   = 1'($urandom_range(0, 1));
            bus_addr  = offs[$urandom_range(0, 5)];
            bus_wdata = 16'($urandom);
            if ($urandom_range(0, 3) == 0) pin_in = 16'($urandom);
            step();
            check_all("R3/R6/R9 random");
        end

        // endpoint mode: low pins carry the alternate interrupt outputs
        alt_irq_n = 4'hA;
        do_reset(1'b1, 16'h5AC3);
        bus_addr = 4'h4; #1;
        chk("R5 pins sampled during endpoint reset", bus_rdata, 16'h5AC3);
        chk("R4 low pins driven after reset", pin_oe, 16'h000F);
        chk("R4 low pins carry alt level", {12'h0, pin_out[3:0]}, 16'h000A);
        write(4'h0, 16'hFFFF);
        write(4'h8, 16'hFFF5);
        chk("R4 override beats registers", pin_oe, 16'h000F);
        check_all("R4 directed");

        for (int i = 0; i < 300; i++) begin
            logic [3:0] offs [5] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h1};
            bus_wen   = 1'($urandom_range(0, 1));
            bus_addr  = offs[$urandom_range(0, 4)];
            bus_wdata = 16'($urandom);
            alt_irq_n = 4'($urandom);
            if ($urandom_range(0, 2) == 0) pin_in = 16'($urandom);
            step();
            check_all("R4/R9 random endpoint");
        end

        finish_run();
    end
endmodule